// File: doc/BRIEF.md
# Chained-Descriptor Block Mover

This block copies data between system memory and a peripheral FIFO under the control of descriptors kept in memory. Software programs the address of the first descriptor, picks a direction and sets a run bit. The engine then reads each descriptor and moves the number of bytes it asks for, one 32-bit word at a time. It follows the descriptor's link to the next one until it reaches a descriptor flagged as the final one.

Each descriptor occupies 16 bytes. Word 0 holds the flags: byte count in bits 15:0, a validity marker in bit 30 and the final flag in bit 31. Word 1 holds the buffer address and word 2 holds the link address. Word 3 is never read. When the run ends, the engine stores a 4-bit outcome code, clears the run bit and raises a sticky completion flag, which can drive an interrupt line.

Top module: `desc_chain_dma`

Register word index (regAddr): 0 global control (bit 0 enable, reads back; bit 8 soft reset, write-only), 1 interrupt enable (bit 0), 2 interrupt status (bit 0, write 1 to clear), 3 first-descriptor address, 4 channel control (bit 22 direction, bit 7 run, bits 3:0 outcome, read-only).

## Requirements
- R1: After reset every register reads 0, irq is 0, and no memory or FIFO request is active.
- R2: The enable bit written at index 0 reads back. A write with bit 8 set sends the engine to idle, clears the run bit and the outcome code, and drops every request.
- R3: Setting the run bit while the enable bit is 0 is ignored. The run bit reads 0 and no memory request follows.
- R4: A descriptor at address A is fetched with exactly three reads, at A, A+4 and A+8, in that order. Each request holds its address until the memory acknowledges it.
- R5: With direction 0, the words of the buffer are read at rising addresses and offered on txData in that order, byte count / 4 words in all. Each offered word stays stable until txReady.
- R6: With direction 1, the words accepted from rxData are written to the buffer at rising addresses, byte count / 4 words in all.
- R7: After a descriptor whose bit 31 is 0, the next descriptor is fetched from its link address. After one whose bit 31 is 1, the run bit clears and the outcome becomes 0xF. The outcome reads 0 while running.
- R8: A descriptor whose flags word has bit 30 clear, or any descriptor read that returns memErr, ends the run with outcome 3.
- R9: A buffer read or write that returns memErr ends the run with outcome 4.
- R10: If periphEnd is asserted while the engine waits on the FIFO before the count is reached, the run ends with outcome 5. Words already moved stay written.
- R11: Every end of run sets the status bit. irq equals status AND interrupt enable. Writing 1 to bit 0 of index 2 clears the status bit.
- R12: With a memory that acknowledges one cycle after each request, a single zero-byte final descriptor raises irq on the 7th rising edge after the edge that samples the run write, and not on the 6th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Single-cycle acknowledge, read data valid |
| memErr | input | 1 | Error, qualified by memAck |
| memRdata | input | 32 | Read data |
| txValid | output | 1 | Word offered to the peripheral |
| txReady | input | 1 | Peripheral takes the word |
| txData | output | 32 | Word to the peripheral |
| rxValid | input | 1 | Peripheral offers a word |
| rxReady | output | 1 | Engine takes the word |
| rxData | input | 32 | Word from the peripheral |
| periphEnd | input | 1 | Peripheral has no more data or space |
| irq | output | 1 | Completion interrupt |

## Verification
A register write takes effect on the edge that samples it, so readbacks are made on the next falling edge. A memory reply advances the engine on the edge where memAck is high. With the bench memory answering one cycle after each request, each descriptor fetch costs six edges plus one decision edge, and the outcome code, the status bit and irq all change on the same edge. The latency check counts falling edges from the run write and samples irq after edge 6 and after edge 7. The other runs wait for irq with a bounded poll and then compare the outcome, the captured FIFO words and the memory contents.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] REG_GCTL = 3'd0;
  localparam logic [REG_AW-1:0] REG_IEN  = 3'd1;
  localparam logic [REG_AW-1:0] REG_ISTS = 3'd2;
  localparam logic [REG_AW-1:0] REG_DPTR = 3'd3;
  localparam logic [REG_AW-1:0] REG_CCTL = 3'd4;
  localparam int BIT_RUN = 7;
  localparam int BIT_DIR = 22;
  localparam int BIT_SRST = 8;
  localparam int BIT_FMT = 30;
  localparam int BIT_LAST = 31;

  typedef enum logic [3:0] {
    EV_NONE = 4'h0, EV_UNDERRUN = 4'h1, EV_OVERRUN = 4'h2,
    EV_DESC_ERR = 4'h3, EV_DATA_ERR = 4'h4, EV_EARLY_END = 4'h5,
    EV_OK = 4'hF
  } evCode_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FLAGS, S_BUF, S_LINK, S_CHECK, S_RDMEM, S_PUSH, S_PULL, S_WRMEM
  } state_t;

  typedef struct packed {
    logic       memReq;
    logic       memWe;
    logic       useBuf;
    logic [1:0] wordSel;
    logic       capFlags;
    logic       capBuf;
    logic       capLink;
    logic       capData;
    logic       advance;
    logic       nextDesc;
    logic       finish;
    evCode_t    code;
    logic       txValid;
    logic       rxReady;
  } strobe_t;
endpackage

// File: rtl/dcd_ctrl.sv
module dcd_ctrl
  import dcd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    softRst,
  input  logic    dir,
  input  logic    endBit,
  input  logic    remainZero,
  input  logic    memAck,
  input  logic    memErr,
  input  logic    memFmtBit,
  input  logic    txReady,
  input  logic    rxValid,
  input  logic    periphEnd,
  output strobe_t st
);
  state_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    st  = '0;
    case (state)
      S_IDLE: if (start) nxt = S_FLAGS;
      S_FLAGS: begin
        st.memReq = 1'b1;
        st.wordSel = 2'd0;
        if (memAck) begin
          if (memErr || !memFmtBit) begin
            st.finish = 1'b1; st.code = EV_DESC_ERR; nxt = S_IDLE;
          end else begin
            st.capFlags = 1'b1; nxt = S_BUF;
          end
        end
      end
      S_BUF: begin
        st.memReq = 1'b1;
        st.wordSel = 2'd1;
        if (memAck) begin
          if (memErr) begin
            st.finish = 1'b1; st.code = EV_DESC_ERR; nxt = S_IDLE;
          end else begin
            st.capBuf = 1'b1; nxt = S_LINK;
          end
        end
      end
      S_LINK: begin
        st.memReq = 1'b1;
        st.wordSel = 2'd2;
        if (memAck) begin
          if (memErr) begin
            st.finish = 1'b1; st.code = EV_DESC_ERR; nxt = S_IDLE;
          end else begin
            st.capLink = 1'b1; nxt = S_CHECK;
          end
        end
      end
      S_CHECK: begin
        if (remainZero) begin
          if (endBit) begin
            st.finish = 1'b1; st.code = EV_OK; nxt = S_IDLE;
          end else begin
            st.nextDesc = 1'b1; nxt = S_FLAGS;
          end
        end else begin
          nxt = dir ? S_PULL : S_RDMEM;
        end
      end
      S_RDMEM: begin
        st.memReq = 1'b1;
        st.useBuf = 1'b1;
        if (memAck) begin
          if (memErr) begin
            st.finish = 1'b1; st.code = EV_DATA_ERR; nxt = S_IDLE;
          end else begin
            st.capData = 1'b1; nxt = S_PUSH;
          end
        end
      end
      S_PUSH: begin
        st.txValid = 1'b1;
        if (txReady) begin
          st.advance = 1'b1; nxt = S_CHECK;
        end else if (periphEnd) begin
          st.finish = 1'b1; st.code = EV_EARLY_END; nxt = S_IDLE;
        end
      end
      S_PULL: begin
        st.rxReady = 1'b1;
        if (rxValid) begin
          st.capData = 1'b1; nxt = S_WRMEM;
        end else if (periphEnd) begin
          st.finish = 1'b1; st.code = EV_EARLY_END; nxt = S_IDLE;
        end
      end
      S_WRMEM: begin
        st.memReq = 1'b1;
        st.memWe = 1'b1;
        st.useBuf = 1'b1;
        if (memAck) begin
          if (memErr) begin
            st.finish = 1'b1; st.code = EV_DATA_ERR; nxt = S_IDLE;
          end else begin
            st.advance = 1'b1; nxt = S_CHECK;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (softRst) nxt = S_IDLE;
  end

  AST_FORMAT_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FLAGS && memAck && !memErr && !memFmtBit) |=> (state == S_IDLE)); // R8
endmodule

// File: rtl/dcd_datapath.sv
module dcd_datapath
  import dcd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [31:0]       memRdata,
  input  logic [31:0]       rxData,
  input  strobe_t           st,
  output logic [31:0]       memAddr,
  output logic [31:0]       dataOut,
  output logic              irq,
  output logic              start,
  output logic              softRst,
  output logic              dir,
  output logic              endBit,
  output logic              remainZero
);
  localparam int RW = CNT_W - 2;

  logic enable, intEn, intStatus, run;
  evCode_t code;
  logic [31:0] descPtr, curDesc, bufAddr, link, dataReg;
  logic [RW-1:0] remain;
  logic wrG, wrE, wrS, wrD, wrC;
  logic unusedBits;

  assign wrG = regWr && (regAddr == REG_GCTL);
  assign wrE = regWr && (regAddr == REG_IEN);
  assign wrS = regWr && (regAddr == REG_ISTS);
  assign wrD = regWr && (regAddr == REG_DPTR);
  assign wrC = regWr && (regAddr == REG_CCTL);
  assign softRst = wrG && regWdata[BIT_SRST];
  assign start = wrC && !run && enable && regWdata[BIT_RUN];
  assign unusedBits = ^regWdata[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0; intEn <= 1'b0; intStatus <= 1'b0; run <= 1'b0;
      dir <= 1'b0; code <= EV_NONE; descPtr <= '0; curDesc <= '0;
      bufAddr <= '0; link <= '0; dataReg <= '0; remain <= '0; endBit <= 1'b0;
    end else begin
      if (wrG) enable <= regWdata[0];
      if (wrE) intEn <= regWdata[0];
      if (wrD) descPtr <= {regWdata[31:2], 2'b00};
      if (softRst) begin
        run <= 1'b0; code <= EV_NONE; intStatus <= 1'b0;
      end else begin
        if (wrS && regWdata[0]) intStatus <= 1'b0;
        if (wrC && !run) dir <= regWdata[BIT_DIR];
        if (start) begin
          run <= 1'b1; code <= EV_NONE; curDesc <= descPtr;
        end
        if (st.finish) begin
          run <= 1'b0; code <= st.code; intStatus <= 1'b1;
        end
      end
      if (st.capFlags) begin
        remain <= memRdata[CNT_W-1:2];
        endBit <= memRdata[BIT_LAST];
      end
      if (st.capBuf) bufAddr <= memRdata;
      if (st.capLink) link <= memRdata;
      if (st.capData) dataReg <= dir ? rxData : memRdata;
      if (st.nextDesc) curDesc <= link;
      if (st.advance) begin
        bufAddr <= bufAddr + 32'd4;
        remain <= remain - 1'b1;
      end
    end
  end

  assign remainZero = (remain == '0);
  assign memAddr = st.useBuf ? bufAddr : (curDesc + {28'd0, st.wordSel, 2'b00});
  assign dataOut = dataReg;
  assign irq = intStatus && intEn;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_GCTL: regRdata[0] = enable;
      REG_IEN:  regRdata[0] = intEn;
      REG_ISTS: regRdata[0] = intStatus;
      REG_DPTR: regRdata = descPtr;
      REG_CCTL: begin
        regRdata[BIT_DIR] = dir;
        regRdata[BIT_RUN] = run;
        regRdata[3:0] = code;
      end
      default: regRdata = '0;
    endcase
  end

  AST_CODE_QUIET_WHILE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (code == EV_NONE)); // R7
  AST_RUN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |-> enable); // R3
  AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(run) && !$past(softRst)) |-> intStatus); // R11
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import dcd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memAck,
  input  logic        memErr,
  input  logic [31:0] memRdata,
  output logic        txValid,
  input  logic        txReady,
  output logic [31:0] txData,
  input  logic        rxValid,
  output logic        rxReady,
  input  logic [31:0] rxData,
  input  logic        periphEnd,
  output logic        irq
);
  strobe_t st;
  logic start, softRst, dir, endBit, remainZero;
  logic [31:0] dataOut;

  dcd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .softRst(softRst), .dir(dir),
    .endBit(endBit), .remainZero(remainZero), .memAck(memAck), .memErr(memErr),
    .memFmtBit(memRdata[BIT_FMT]), .txReady(txReady), .rxValid(rxValid),
    .periphEnd(periphEnd), .st(st)
  );

  dcd_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memRdata(memRdata),
    .rxData(rxData), .st(st), .memAddr(memAddr), .dataOut(dataOut), .irq(irq),
    .start(start), .softRst(softRst), .dir(dir), .endBit(endBit),
    .remainZero(remainZero)
  );

  assign memReq = st.memReq;
  assign memWe = st.memWe;
  assign memWdata = dataOut;
  assign txValid = st.txValid;
  assign txData = dataOut;
  assign rxReady = st.rxReady;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !softRst) |=> (memReq && $stable(memAddr))); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !periphEnd && !softRst) |=> (txValid && $stable(txData))); // R5
endmodule

// File: tb/desc_chain_dma_tb_top.sv
`timescale 1ns/1ps
module desc_chain_dma_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic regWr = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic memReq, memWe, memAck, memErr;
  logic [31:0] memAddr, memWdata, memRdata;
  logic txValid, txReady, rxValid, rxReady, periphEnd, irq;
  logic [31:0] txData, rxData;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:255];
  logic [31:0] rdLog [0:15];
  int rdCnt = 0;
  logic logClr = 1'b0;
  logic [31:0] txLog [0:15];
  int txCnt = 0;
  logic txClr = 1'b0;
  int rxIdx = 0;
  logic rxClr = 1'b0;
  logic rxOn = 1'b0;
  int rxLimit = 0;
  logic endOn = 1'b0;
  logic txRdyOn = 1'b1;

  desc_chain_dma dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memErr(memErr), .memRdata(memRdata),
    .txValid(txValid), .txReady(txReady), .txData(txData), .rxValid(rxValid),
    .rxReady(rxReady), .rxData(rxData), .periphEnd(periphEnd), .irq(irq)
  );

  // memory model: one-cycle acknowledge, error above 1 KiB
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAck <= 1'b0; memErr <= 1'b0; memRdata <= '0;
    end else begin
      memAck <= 1'b0; memErr <= 1'b0;
      if (logClr) rdCnt <= 0;
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        if (memAddr[31:10] != 0) memErr <= 1'b1;
        else if (memWe) mem[memAddr[9:2]] <= memWdata;
        else memRdata <= mem[memAddr[9:2]];
        if (!memWe && !logClr && rdCnt < 16) begin
          rdLog[rdCnt] <= memAddr;
          rdCnt <= rdCnt + 1;
        end
      end
    end
  end

  assign txReady = txRdyOn;
  always @(posedge clk) begin
    if (txClr) txCnt <= 0;
    else if (txValid && txReady && txCnt < 16) begin
      txLog[txCnt] <= txData;
      txCnt <= txCnt + 1;
    end
  end

  assign rxValid = rxOn && (rxIdx < rxLimit);
  assign rxData = 32'hA500_0000 | rxIdx;
  assign periphEnd = endOn && (rxIdx >= rxLimit);
  always @(posedge clk) begin
    if (rxClr) rxIdx <= 0;
    else if (rxValid && rxReady) rxIdx <= rxIdx + 1;
  end

  localparam int NV = 4;
  localparam int VDIR [NV] = '{0, 1, 0, 1};
  localparam int VBYTES [NV] = '{4, 12, 32, 20};
  localparam int VBUF [NV] = '{32'h300, 32'h340, 32'h380, 32'h3C0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pulseClears();
    @(negedge clk);
    logClr = 1'b1; txClr = 1'b1; rxClr = 1'b1;
    @(negedge clk);
    logClr = 1'b0; txClr = 1'b0; rxClr = 1'b0;
  endtask

  task automatic waitIrq(input string req);
    int n;
    n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!irq) begin
      checks++; errors++;
      $display("FAIL %s actual irq timeout expected completion", req);
    end
  endtask

  task automatic putDesc(input int at, input logic [31:0] flags, input logic [31:0] buf0,
                         input logic [31:0] link);
    mem[at/4] = flags; mem[at/4+1] = buf0; mem[at/4+2] = link; mem[at/4+3] = 32'hDEAD_BEEF;
  endtask

  task automatic runFrom(input int ptr, input logic d);
    regWrite(3'd3, ptr);
    regWrite(3'd4, (32'(d) << 22) | 32'h80);
  endtask

  task automatic clearSts();
    regWrite(3'd2, 32'h1);
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), r);
      chk("R1 register reset", r, 32'h0);
    end
    chk("R1 irq reset", {31'd0, irq}, 32'h0);
    chk("R1 no requests", {29'd0, memReq, txValid, rxReady}, 32'h0);

    // R3 run without enable
    regWrite(3'd3, 32'h40);
    regWrite(3'd4, 32'h80);
    repeat (5) @(negedge clk);
    regRead(3'd4, r);
    chk("R3 run ignored while disabled", r, 32'h0);
    chk("R3 no memory request", {31'd0, memReq}, 32'h0);

    // R2 enable readback
    regWrite(3'd0, 32'h1);
    regRead(3'd0, r);
    chk("R2 enable readback", r, 32'h1);
    regWrite(3'd1, 32'h1);

    // R12 latency, R4 fetch order, R7 final descriptor
    putDesc(32'h40, 32'hC000_0000, 32'h0, 32'h0);
    pulseClears();
    runFrom(32'h40, 1'b0);
    repeat (6) @(negedge clk);
    chk("R12 irq not before edge 7", {31'd0, irq}, 32'h0);
    @(negedge clk);
    chk("R12 irq at edge 7", {31'd0, irq}, 32'h1);
    chk("R4 read count", rdCnt, 3);
    chk("R4 first read", rdLog[0], 32'h40);
    chk("R4 second read", rdLog[1], 32'h44);
    chk("R4 third read", rdLog[2], 32'h48);
    regRead(3'd4, r);
    chk("R7 success code and run clear", r, 32'hF);
    clearSts();

    // R5 / R6 vector table
    for (int v = 0; v < NV; v++) begin
      putDesc(0, 32'hC000_0000 | VBYTES[v], VBUF[v], 32'h0);
      for (int i = 0; i < VBYTES[v] / 4; i++) mem[VBUF[v]/4 + i] = 32'h1000_0000 + v * 256 + i;
      rxOn = 1'b1; rxLimit = 100; endOn = 1'b0;
      pulseClears();
      runFrom(0, VDIR[v] != 0);
      waitIrq("R5/R6 vector run");
      regRead(3'd4, r);
      chk("R5/R6 vector outcome", r[3:0], 32'hF);
      if (VDIR[v] == 0) begin
        chk("R5 word count", txCnt, VBYTES[v] / 4);
        for (int i = 0; i < VBYTES[v] / 4; i++)
          chk("R5 word order", txLog[i], 32'h1000_0000 + v * 256 + i);
      end else begin
        chk("R6 no tx words", txCnt, 0);
        for (int i = 0; i < VBYTES[v] / 4; i++)
          chk("R6 stored word", mem[VBUF[v]/4 + i], 32'hA500_0000 | i);
        chk("R6 word count", rxIdx, VBYTES[v] / 4);
      end
      clearSts();
    end
    rxOn = 1'b0;

    // R7 chain of two descriptors
    putDesc(32'h100, 32'h4000_0008, 32'h200, 32'h180);
    putDesc(32'h180, 32'hC000_0004, 32'h210, 32'h0);
    mem[32'h80] = 32'h11; mem[32'h81] = 32'h22; mem[32'h84] = 32'h33;
    pulseClears();
    runFrom(32'h100, 1'b0);
    waitIrq("R7 chain");
    chk("R7 chain word count", txCnt, 3);
    chk("R7 chain word 0", txLog[0], 32'h11);
    chk("R7 chain word 1", txLog[1], 32'h22);
    chk("R7 chain word 2", txLog[2], 32'h33);
    regRead(3'd4, r);
    chk("R7 chain outcome", r, 32'hF);
    clearSts();

    // R8 bad format and descriptor read error
    putDesc(32'h20, 32'h0000_0004, 32'h300, 32'h0);
    pulseClears();
    runFrom(32'h20, 1'b0);
    waitIrq("R8 format");
    regRead(3'd4, r);
    chk("R8 format outcome", r, 32'h3);
    chk("R8 no data moved", txCnt, 0);
    clearSts();
    runFrom(32'h1000, 1'b0);
    waitIrq("R8 fetch error");
    regRead(3'd4, r);
    chk("R8 fetch error outcome", r, 32'h3);
    clearSts();

    // R9 data access error
    putDesc(32'h20, 32'hC000_0008, 32'h2000, 32'h0);
    runFrom(32'h20, 1'b0);
    waitIrq("R9 data error");
    regRead(3'd4, r);
    chk("R9 data error outcome", r, 32'h4);
    clearSts();

    // R10 early end from the peripheral
    putDesc(32'h20, 32'hC000_0010, 32'h300, 32'h0);
    mem[32'hC0] = '0; mem[32'hC1] = '0; mem[32'hC2] = '0;
    pulseClears();
    rxOn = 1'b1; rxLimit = 2; endOn = 1'b1;
    runFrom(32'h20, 1'b1);
    waitIrq("R10 early end");
    regRead(3'd4, r);
    chk("R10 early end outcome", r[7:0], 32'h5);
    chk("R10 word 0 kept", mem[32'hC0], 32'hA500_0000);
    chk("R10 word 1 kept", mem[32'hC1], 32'hA500_0001);
    chk("R10 word 2 untouched", mem[32'hC2], 32'h0);
    clearSts();
    rxOn = 1'b0; endOn = 1'b0;

    // R11 interrupt masking and clearing
    regWrite(3'd1, 32'h0);
    runFrom(32'h40, 1'b0);
    repeat (12) @(negedge clk);
    regRead(3'd2, r);
    chk("R11 status set", r, 32'h1);
    chk("R11 irq masked", {31'd0, irq}, 32'h0);
    regWrite(3'd1, 32'h1);
    chk("R11 irq unmasked", {31'd0, irq}, 32'h1);
    clearSts();
    regRead(3'd2, r);
    chk("R11 status cleared", r, 32'h0);
    chk("R11 irq cleared", {31'd0, irq}, 32'h0);

    // R2 soft reset on a stalled run and after a completed one
    putDesc(32'h20, 32'hC000_0008, 32'h300, 32'h0);
    runFrom(32'h20, 1'b1);
    repeat (20) @(negedge clk);
    regRead(3'd4, r);
    chk("R2 stalled run active", {31'd0, r[7]}, 32'h1);
    regWrite(3'd0, 32'h101);
    regRead(3'd4, r);
    chk("R2 soft reset clears run and code", r & 32'hFF, 32'h0);
    chk("R2 soft reset drops requests", {30'd0, rxReady, memReq}, 32'h0);
    regRead(3'd0, r);
    chk("R2 enable after soft reset", r, 32'h1);
    runFrom(32'h40, 1'b0);
    waitIrq("R2 run after soft reset");
    regRead(3'd4, r);
    chk("R2 code before soft reset", r[3:0], 32'hF);
    regWrite(3'd0, 32'h101);
    regRead(3'd4, r);
    chk("R2 code cleared by soft reset", r[3:0], 32'h0);
    chk("R2 irq cleared by soft reset", {31'd0, irq}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule